// File: doc/BRIEF.md
# Turn-Model Mesh Route Computation

This unit decides where a head flit may go next inside one router of a two-dimensional mesh that has no wraparound links. It is given the router's own coordinates, the destination coordinates carried by the head flit and a two-bit routing mode. From these it produces two results: a mask of every output port the selected turn model permits, and one chosen port. East increases X, West decreases X, North increases Y and South decreases Y. The Local port delivers the flit to the attached node.

Four modes are supported. The first is plain dimension-order routing. The other three are adaptive turn models, each of which forbids a different pair of turns so that no cyclic channel dependency can form. When a mode leaves both an X port and a Y port legal, per-port congestion levels decide which of the two is chosen.

A request is a single-cycle pulse of `req_valid`. One clock edge later the response appears with `rsp_valid` high. Body and tail flits never reach this unit. Virtual-channel choice and buffering are handled elsewhere.

Top module: `mesh_route_unit`

## Requirements
- R1: Only productive ports are ever placed in `rsp_mask`. A port is productive when a hop through it reduces the distance to the destination. When the destination equals the current node, in every mode, `rsp_mask` is 5'b00001 and `rsp_port` is 0 (Local). Mask bit i belongs to port code i, with the codes Local=0, East=1, West=2, North=3, South=4.
- R2: In mode 2'b00 (dimension-order), the mask holds only the productive X port while the X coordinates differ. Once the X coordinates match, the mask holds only the productive Y port.
- R3: In mode 2'b01 (west-first), when West is productive the mask is exactly West. Otherwise every productive port among East, North and South is permitted.
- R4: In mode 2'b10 (north-last), North is permitted only when no other direction is productive. All other productive ports are permitted.
- R5: In mode 2'b11 (negative-first), when West or South is productive the mask holds only the productive ports among West and South. Otherwise it holds the productive ports among East and North.
- R6: When the mask holds one X port and one Y port, the chosen port is the one whose congestion input is strictly lower. On equal values the X port is chosen.
- R7: `rsp_valid` is high exactly one cycle after each cycle in which `req_valid` is high. In a cycle after `req_valid` was low, `rsp_valid` is low and `rsp_mask` and `rsp_port` keep their previous values.
- R8: After reset, `rsp_valid`, `rsp_mask` and `rsp_port` are all zero.
- R9: Whenever `rsp_valid` is high, `rsp_port` names a port whose bit is set in `rsp_mask`, and the mask has one or two bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A head flit requests a route this cycle |
| cur_x | input | COORD_W | X coordinate of this router |
| cur_y | input | COORD_W | Y coordinate of this router |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| mode | input | 2 | Turn model: 00 XY, 01 west-first, 10 north-last, 11 negative-first |
| cong_e | input | CONG_W | Congestion level of the East output |
| cong_w | input | CONG_W | Congestion level of the West output |
| cong_n | input | CONG_W | Congestion level of the North output |
| cong_s | input | CONG_W | Congestion level of the South output |
| rsp_valid | output | 1 | Response valid |
| rsp_mask | output | 5 | Permitted ports, bit i is port code i |
| rsp_port | output | 3 | Chosen port code |

## Verification
The hardest case to reach is the one where the congestion comparison actually decides the result. This needs an adaptive mode whose rules leave two ports legal, together with congestion values that are equal, or that favour the Y port by exactly one step. Random traffic rarely produces this combination. The stimulus therefore places the destination diagonally in each quadrant allowed by each mode and forces equal and near-equal congestion levels. It then sweeps every source and destination pair of the default 8x8 grid in all four modes, with back-to-back requests and congestion values drawn from a small range so that ties stay frequent.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = $clog2(NUM_PORTS);

    // port codes; mask bit i belongs to code i
    localparam logic [PORT_W-1:0] PORT_LOCAL = PORT_W'(0);
    localparam logic [PORT_W-1:0] PORT_EAST  = PORT_W'(1);
    localparam logic [PORT_W-1:0] PORT_WEST  = PORT_W'(2);
    localparam logic [PORT_W-1:0] PORT_NORTH = PORT_W'(3);
    localparam logic [PORT_W-1:0] PORT_SOUTH = PORT_W'(4);

    typedef enum logic [1:0] {
        MODE_XY         = 2'b00,
        MODE_WEST_FIRST = 2'b01,
        MODE_NORTH_LAST = 2'b10,
        MODE_NEG_FIRST  = 2'b11
    } route_mode_e;

    typedef struct packed {
        logic east;
        logic west;
        logic north;
        logic south;
    } dir_set_t;

    typedef struct packed {
        logic                 valid;
        logic [NUM_PORTS-1:0] mask;
        logic [PORT_W-1:0]    port;
    } route_rsp_t;

endpackage

// File: rtl/mesh_dir_detect.sv
module mesh_dir_detect
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output dir_set_t           prod,
    output logic               arrived
);
    always_comb begin
        prod.east  = dst_x > cur_x;
        prod.west  = dst_x < cur_x;
        prod.north = dst_y > cur_y;
        prod.south = dst_y < cur_y;
        arrived    = (dst_x == cur_x) && (dst_y == cur_y);
    end
endmodule

// File: rtl/mesh_turn_filter.sv
module mesh_turn_filter
    import mesh_route_pkg::*;
(
    input  logic [1:0] mode,
    input  dir_set_t   prod,
    output dir_set_t   legal
);
    logic x_any;
    logic non_north;
    logic neg_any;

    always_comb begin
        x_any     = prod.east | prod.west;
        non_north = prod.east | prod.west | prod.south;
        neg_any   = prod.west | prod.south;
        legal     = prod;
        case (route_mode_e'(mode))
            MODE_XY: begin
                legal.north = prod.north & ~x_any;
                legal.south = prod.south & ~x_any;
            end
            MODE_WEST_FIRST: begin
                if (prod.west) begin
                    legal.east  = 1'b0;
                    legal.north = 1'b0;
                    legal.south = 1'b0;
                end
            end
            MODE_NORTH_LAST: begin
                legal.north = prod.north & ~non_north;
            end
            MODE_NEG_FIRST: begin
                if (neg_any) begin
                    legal.east  = 1'b0;
                    legal.north = 1'b0;
                end
            end
            default: legal = prod;
        endcase
    end
endmodule

// File: rtl/mesh_port_select.sv
module mesh_port_select
    import mesh_route_pkg::*;
#(
    parameter int CONG_W = 4
) (
    input  dir_set_t              legal,
    input  logic                  arrived,
    input  logic [CONG_W-1:0]     cong_e,
    input  logic [CONG_W-1:0]     cong_w,
    input  logic [CONG_W-1:0]     cong_n,
    input  logic [CONG_W-1:0]     cong_s,
    output logic [NUM_PORTS-1:0]  mask,
    output logic [PORT_W-1:0]     port
);
    logic              x_ok;
    logic              y_ok;
    logic [CONG_W-1:0] x_cong;
    logic [CONG_W-1:0] y_cong;
    logic [PORT_W-1:0] x_code;
    logic [PORT_W-1:0] y_code;

    always_comb begin
        mask = '0;
        mask[PORT_LOCAL] = arrived;
        mask[PORT_EAST]  = legal.east;
        mask[PORT_WEST]  = legal.west;
        mask[PORT_NORTH] = legal.north;
        mask[PORT_SOUTH] = legal.south;

        x_ok   = legal.east | legal.west;
        y_ok   = legal.north | legal.south;
        x_cong = legal.east  ? cong_e    : cong_w;
        y_cong = legal.north ? cong_n    : cong_s;
        x_code = legal.east  ? PORT_EAST : PORT_WEST;
        y_code = legal.north ? PORT_NORTH : PORT_SOUTH;

        if (arrived || !(x_ok || y_ok)) begin
            port = PORT_LOCAL;
        end else if (x_ok && y_ok) begin
            port = (y_cong < x_cong) ? y_code : x_code;
        end else if (x_ok) begin
            port = x_code;
        end else begin
            port = y_code;
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int CONG_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [1:0]         mode,
    input  logic [CONG_W-1:0]  cong_e,
    input  logic [CONG_W-1:0]  cong_w,
    input  logic [CONG_W-1:0]  cong_n,
    input  logic [CONG_W-1:0]  cong_s,
    output logic               rsp_valid,
    output logic [4:0]         rsp_mask,
    output logic [2:0]         rsp_port
);
    dir_set_t             prod;
    dir_set_t             legal;
    logic                 arrived;
    logic [NUM_PORTS-1:0] mask_w;
    logic [PORT_W-1:0]    port_w;
    route_rsp_t           rsp_d;
    route_rsp_t           rsp_q;

    mesh_dir_detect #(.COORD_W(COORD_W)) u_dir (
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .dst_x   (dst_x),
        .dst_y   (dst_y),
        .prod    (prod),
        .arrived (arrived)
    );

    mesh_turn_filter u_filter (
        .mode  (mode),
        .prod  (prod),
        .legal (legal)
    );

    mesh_port_select #(.CONG_W(CONG_W)) u_sel (
        .legal   (legal),
        .arrived (arrived),
        .cong_e  (cong_e),
        .cong_w  (cong_w),
        .cong_n  (cong_n),
        .cong_s  (cong_s),
        .mask    (mask_w),
        .port    (port_w)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.mask = mask_w;
            rsp_d.port = port_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_mask  = rsp_q.mask;
    assign rsp_port  = rsp_q.port;
endmodule

// File: rtl/mesh_route_unit_chk.sv
module mesh_route_unit_chk #(
    parameter int COORD_W = 3,
    parameter int CONG_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic [COORD_W-1:0] dst_x,
    input logic [COORD_W-1:0] dst_y,
    input logic [1:0]         mode,
    input logic               rsp_valid,
    input logic [4:0]         rsp_mask,
    input logic [2:0]         rsp_port
);
    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R7
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_mask) && $stable(rsp_port)));
    // R9
    port_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_port < 3'd5 && rsp_mask[rsp_port]));
    // R9
    mask_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_mask) >= 1 && $countones(rsp_mask) <= 2));
    // R1
    local_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dst_x == cur_x && dst_y == cur_y) |=> (rsp_mask == 5'b00001));
    // R2
    xy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b00) |=> $onehot0(rsp_mask));
    // R3
    west_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b01 && dst_x < cur_x) |=> (rsp_mask == 5'b00100));
    // R4
    north_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b10 && dst_x != cur_x) |=> !rsp_mask[3]);
    // R5
    neg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b11 && (dst_x < cur_x || dst_y < cur_y))
        |=> (!rsp_mask[1] && !rsp_mask[3]));
endmodule

bind mesh_route_unit mesh_route_unit_chk #(.COORD_W(COORD_W), .CONG_W(CONG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .dst_x     (dst_x),
    .dst_y     (dst_y),
    .mode      (mode),
    .rsp_valid (rsp_valid),
    .rsp_mask  (rsp_mask),
    .rsp_port  (rsp_port)
);

// File: tb/tb_mesh_route_unit.sv
`timescale 1ns/1ps
module tb_mesh_route_unit;
    localparam int CW = 3;
    localparam int GW = 4;
    localparam int SPAN = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [1:0]    mode = '0;
    logic [GW-1:0] cong_e = '0, cong_w = '0, cong_n = '0, cong_s = '0;
    logic          rsp_valid;
    logic [4:0]    rsp_mask;
    logic [2:0]    rsp_port;

    int n_checks = 0;
    int n_fail   = 0;
    logic [4:0] last_mask = '0;
    logic [2:0] last_port = '0;

    logic [4:0] q_mask[$];
    logic [2:0] q_port[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    mesh_route_unit #(.COORD_W(CW), .CONG_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .mode(mode), .cong_e(cong_e), .cong_w(cong_w), .cong_n(cong_n),
        .cong_s(cong_s), .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
        .rsp_port(rsp_port)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // reference model written from the requirement text
    task automatic model(input int cx, cy, dx, dy, md, ce, cw, cn, cs,
                         output logic [4:0] m, output logic [2:0] p);
        bit go_e, go_w, go_n, go_s;
        bit ok_e, ok_w, ok_n, ok_s;
        go_e = dx > cx; go_w = dx < cx; go_n = dy > cy; go_s = dy < cy;
        ok_e = 0; ok_w = 0; ok_n = 0; ok_s = 0;
        if (md == 0) begin
            if (go_e || go_w) begin ok_e = go_e; ok_w = go_w; end
            else begin ok_n = go_n; ok_s = go_s; end
        end else if (md == 1) begin
            if (go_w) ok_w = 1;
            else begin ok_e = go_e; ok_n = go_n; ok_s = go_s; end
        end else if (md == 2) begin
            ok_e = go_e; ok_w = go_w; ok_s = go_s;
            ok_n = go_n && !(go_e || go_w || go_s);
        end else begin
            if (go_w || go_s) begin ok_w = go_w; ok_s = go_s; end
            else begin ok_e = go_e; ok_n = go_n; end
        end
        m = {ok_s, ok_n, ok_w, ok_e, !(go_e || go_w || go_n || go_s)};
        if (m[0]) p = 3'd0;
        else if ((ok_e || ok_w) && (ok_n || ok_s)) begin
            if ((ok_n ? cn : cs) < (ok_e ? ce : cw)) p = ok_n ? 3'd3 : 3'd4;
            else p = ok_e ? 3'd1 : 3'd2;
        end else if (ok_e) p = 3'd1;
        else if (ok_w) p = 3'd2;
        else if (ok_n) p = 3'd3;
        else p = 3'd4;
    endtask

    task automatic send(input int cx, cy, dx, dy, md, ce, cw, cn, cs, input string tag);
        logic [4:0] m;
        logic [2:0] p;
        @(negedge clk);
        cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
        mode = 2'(md);
        cong_e = GW'(ce); cong_w = GW'(cw); cong_n = GW'(cn); cong_s = GW'(cs);
        req_valid = 1'b1;
        model(cx, cy, dx, dy, md, ce, cw, cn, cs, m, p);
        q_mask.push_back(m); q_port.push_back(p); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_mask.size() == 0) begin
                check(1'b0, "R7 unexpected rsp_valid", 1, 0);
            end else begin
                logic [4:0] em;
                logic [2:0] ep;
                string t;
                em = q_mask.pop_front(); ep = q_port.pop_front(); t = q_tag.pop_front();
                check(rsp_mask == em, {t, " mask"}, rsp_mask, em);
                check(rsp_port == ep, {t, " port (R9)"}, rsp_port, ep);
                last_mask = em; last_port = ep;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(rsp_valid == 0, "R8 rsp_valid", rsp_valid, 0);
        check(rsp_mask == 0, "R8 rsp_mask", rsp_mask, 0);
        check(rsp_port == 0, "R8 rsp_port", rsp_port, 0);
        rst_n = 1'b1;
        idle(1);

        // R1 arrival, every mode
        for (int md = 0; md < 4; md++) send(3, 3, 3, 3, md, 1, 1, 1, 1, "R1 local");
        // R2 dimension order
        send(3, 3, 5, 1, 0, 9, 9, 0, 0, "R2 x first");
        send(3, 3, 3, 6, 0, 0, 0, 9, 0, "R2 y after x");
        // R3 west-first
        send(3, 3, 1, 5, 1, 0, 15, 0, 0, "R3 west only");
        send(3, 3, 5, 5, 1, 5, 0, 2, 0, "R3/R6 y less congested");
        // R4 north-last
        send(3, 3, 5, 6, 2, 9, 0, 0, 0, "R4 north withheld");
        send(3, 3, 3, 6, 2, 0, 0, 4, 0, "R4 north last");
        send(3, 3, 5, 1, 2, 3, 0, 0, 3, "R4/R6 tie to x");
        // R5 negative-first
        send(3, 3, 1, 6, 3, 0, 0, 0, 0, "R5 west before north");
        send(3, 3, 5, 1, 3, 0, 0, 0, 0, "R5 south before east");
        send(3, 3, 1, 1, 3, 0, 7, 0, 2, "R5/R6 south chosen");
        send(3, 3, 6, 6, 3, 4, 0, 3, 0, "R5/R6 north by one");
        idle(3);
        // R7 hold while idle
        check(rsp_valid == 0, "R7 valid low idle", rsp_valid, 0);
        check(rsp_mask == last_mask, "R7 mask held", rsp_mask, last_mask);
        check(rsp_port == last_port, "R7 port held", rsp_port, last_port);

        // full sweep, back to back
        for (int md = 0; md < 4; md++)
            for (int cx = 0; cx < SPAN; cx++)
                for (int cy = 0; cy < SPAN; cy++)
                    for (int dx = 0; dx < SPAN; dx++)
                        for (int dy = 0; dy < SPAN; dy++)
                            send(cx, cy, dx, dy, md, $urandom % 4, $urandom % 4,
                                 $urandom % 4, $urandom % 4,
                                 md == 0 ? "R2 sweep" : md == 1 ? "R3 sweep" :
                                 md == 2 ? "R4 sweep" : "R5 sweep");
        idle(3);
        check(q_mask.size() == 0, "R7 all responses seen", q_mask.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule